// File: doc/BRIEF.md
# Pre-trigger capture controller

This block sequences a logic-analyser capture into a sample buffer that it does not own. At each sample strobe it emits a write enable, a buffer address and the current channel word. The strobe comes either from a programmable divider on the base clock or from a chosen edge of an external sample clock. A capture starts on an arm pulse, which latches the mode word, divider, length and requested pre-trigger depth.

The controller first fills a circular region so that a fixed number of samples from before the trigger event is always held. Once that many samples exist, the first sample on which the trigger condition holds becomes the trigger sample. From that sample on, the remaining part of the capture is written and then the done flag rises. The buffer address of the trigger sample is latched once so that the reader can unroll the circular region. The capture length is given in units of 16 samples. The requested pre-trigger depth is clamped against a limit that depends on the mode, and it is aligned down to 64-sample granularity.

Top module: `pcap_ctrl`

## Requirements
- R1: With internal clocking (mode bit 1 clear), one sample is taken every N base-clock cycles, where N is `divider_i`, and a divider of 0 acts as 1. The first write appears N cycles after the clock edge that accepts `arm_i`, and the write data is the `sample_i` value present in the cycle of its strobe.
- R2: Write addresses run 0, 1, 2, … and wrap to 0 after total−1, where total is the capture length in samples. No write address is ever outside that range.
- R3: The capture length in samples is `len_units_i` × 16. A unit count of 0 acts as 1, and the length is capped at the buffer depth of 2^ADDR_W samples.
- R4: The effective pre-trigger depth is computed in this order. The request is first capped at 90 % of the buffer depth, or at 10 % when mode bit 12 (streaming) is set. It is then rounded down to a multiple of 64 and raised to at least 64. Last, it is limited to total−16.
- R5: The trigger is only accepted on a sample that is preceded by at least the effective pre-trigger depth of samples since arming. An earlier trigger condition is ignored, and the trigger sample is then the first sample of that depth.
- R6: Starting with the trigger sample, exactly total − pretrigger samples are written. `done_o` rises in the same cycle as the last write, and no further write occurs until the next arm.
- R7: `trig_seen_o` rises together with the write of the trigger sample. `trig_idx_o` then holds that sample's write address and stays unchanged until the next arm.
- R8: With mode bit 0 clear the trigger input is ignored and the trigger is taken at once, on sample number pretrigger. The run then writes exactly total samples.
- R9: With mode bit 1 set, one sample is taken per rising edge of `ext_clk_i`, or per falling edge when mode bit 2 is also set, and the divider has no effect.
- R10: `arm_i` restarts a capture at any time, including mid-run. On the next cycle `done_o` and `trig_seen_o` are low.
- R11: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Start pulse; latches all settings |
| mode_i | input | 16 | Mode word: bit 0 trigger enable, bit 1 external clock, bit 2 falling edge, bit 12 streaming |
| divider_i | input | DIV_W | Base clocks per sample |
| len_units_i | input | CNT_W | Capture length in 16-sample units |
| pretrig_i | input | CNT_W | Requested pre-trigger depth in samples |
| trig_i | input | 1 | Trigger condition, sampled on each strobe |
| ext_clk_i | input | 1 | External sample clock |
| sample_i | input | CH_W | Channel word |
| strobe_o | output | 1 | Sample strobe taken in the previous cycle |
| wr_en_o | output | 1 | Buffer write enable |
| wr_addr_o | output | ADDR_W | Buffer write address |
| wr_data_o | output | CH_W | Buffer write data |
| done_o | output | 1 | Capture complete |
| trig_seen_o | output | 1 | Trigger sample has been written |
| trig_idx_o | output | ADDR_W | Buffer address of the trigger sample |

## Verification
The assertions check the following on every cycle: write addresses stay inside the capture region, the trigger flag and index hold once set, done comes only with a write after a trigger, nothing is written once done, and arming clears the state. Only the bench scenarios can show the arithmetic: the clamp and alignment chain of the pre-trigger depth, the exact write count, the strobe spacing for each divider, which sample becomes the trigger for early and late trigger conditions, and the choice of edge in external-clock mode.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  localparam int MODE_W        = 16;
  localparam int MODE_TRIG_EN  = 0;
  localparam int MODE_EXT_CLK  = 1;
  localparam int MODE_EXT_FALL = 2;
  localparam int MODE_STREAM   = 12;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_POST,
    ST_DONE
  } cap_state_e;
endpackage

// File: rtl/pcap_depth_calc.sv
module pcap_depth_calc #(
  parameter int ADDR_W   = 14,
  parameter int CNT_W    = 32,
  parameter int UNIT     = 16,
  parameter int ALIGN    = 64,
  parameter int BUF_PCT  = 90,
  parameter int STRM_PCT = 10
) (
  input  logic [CNT_W-1:0]  units_i,
  input  logic [CNT_W-1:0]  pre_req_i,
  input  logic              stream_i,
  output logic [ADDR_W:0]   total_o,
  output logic [ADDR_W:0]   pre_o
);
  localparam int TW        = ADDR_W + 1;
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int UNITS_MAX = DEPTH / UNIT;
  localparam int BUF_LIM   = ((DEPTH * BUF_PCT) / 100 / ALIGN) * ALIGN;
  localparam int STRM_LIM  = ((DEPTH * STRM_PCT) / 100 / ALIGN) * ALIGN;
  localparam logic [CNT_W-1:0] ALIGN_MASK = ~CNT_W'(ALIGN - 1);

  logic [CNT_W-1:0] units_eff, lim, p_cap, p_aln, p_flr;
  logic [TW-1:0]    room;

  always_comb begin
    units_eff = (units_i == '0) ? CNT_W'(1) : units_i;
    total_o   = (units_eff >= CNT_W'(UNITS_MAX)) ? TW'(DEPTH)
                                                 : TW'(units_eff * CNT_W'(UNIT));
    // cap, align down, floor, then keep one unit of post-trigger room
    lim   = stream_i ? CNT_W'(STRM_LIM) : CNT_W'(BUF_LIM);
    p_cap = (pre_req_i > lim) ? lim : pre_req_i;
    p_aln = p_cap & ALIGN_MASK;
    p_flr = (p_aln < CNT_W'(ALIGN)) ? CNT_W'(ALIGN) : p_aln;
    room  = total_o - TW'(UNIT);
    pre_o = (p_flr > CNT_W'(room)) ? room : TW'(p_flr);
  end
endmodule

// File: rtl/pcap_strobe_gen.sv
module pcap_strobe_gen #(
  parameter int DIV_W  = 32,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             ext_sel_i,
  input  logic             ext_fall_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ext_clk_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, last;
  logic [SYNC_N:0]  sync_q;
  logic             int_hit, ext_edge, cur, prev;

  assign last     = (div_i == '0) ? '0 : div_i - DIV_W'(1);
  assign int_hit  = (cnt_q == last);
  assign cur      = sync_q[SYNC_N-1];
  assign prev     = sync_q[SYNC_N];
  assign ext_edge = ext_fall_i ? (prev & ~cur) : (~prev & cur);
  assign tick_o   = en_i & (ext_sel_i ? ext_edge : int_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_N-1:0], ext_clk_i};
      if (clr_i || !en_i || int_hit) cnt_q <= '0;
      else                           cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/pcap_sequencer.sv
module pcap_sequencer
  import pcap_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int CH_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              tick_i,
  input  logic              trig_i,
  input  logic              trig_en_i,
  input  logic [CH_W-1:0]   sample_i,
  input  logic [ADDR_W:0]   total_i,
  input  logic [ADDR_W:0]   pre_i,
  output logic              run_o,
  output logic              strobe_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [CH_W-1:0]   wr_data_o,
  output logic              done_o,
  output logic              trig_seen_o,
  output logic [ADDR_W-1:0] trig_idx_o,
  output logic [ADDR_W:0]   total_o
);
  localparam int TW = ADDR_W + 1;

  cap_state_e    state_q;
  logic [TW-1:0] addr_q, fill_q, post_left_q, pre_q, total_q;
  logic          active, fire;

  assign active  = (state_q == ST_PRE) || (state_q == ST_POST);
  assign run_o   = active;
  assign total_o = total_q;
  assign fire    = (state_q == ST_PRE) && (fill_q == pre_q) && (trig_i || !trig_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      fill_q      <= '0;
      post_left_q <= '0;
      pre_q       <= '0;
      total_q     <= '0;
      strobe_o    <= 1'b0;
      wr_en_o     <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      done_o      <= 1'b0;
      trig_seen_o <= 1'b0;
      trig_idx_o  <= '0;
    end else begin
      strobe_o <= 1'b0;
      wr_en_o  <= 1'b0;
      if (arm_i) begin
        state_q     <= ST_PRE;
        addr_q      <= '0;
        fill_q      <= '0;
        post_left_q <= '0;
        pre_q       <= pre_i;
        total_q     <= total_i;
        done_o      <= 1'b0;
        trig_seen_o <= 1'b0;
        trig_idx_o  <= '0;
      end else if (tick_i && active) begin
        strobe_o  <= 1'b1;
        wr_en_o   <= 1'b1;
        wr_addr_o <= addr_q[ADDR_W-1:0];
        wr_data_o <= sample_i;
        addr_q    <= (addr_q == total_q - TW'(1)) ? '0 : addr_q + TW'(1);
        if (state_q == ST_PRE) begin
          if (fire) begin
            // trigger sample is the first of the post-trigger run
            trig_seen_o <= 1'b1;
            trig_idx_o  <= addr_q[ADDR_W-1:0];
            post_left_q <= total_q - pre_q - TW'(1);
            state_q     <= ST_POST;
          end else if (fill_q != pre_q) begin
            fill_q <= fill_q + TW'(1);
          end
        end else begin
          post_left_q <= post_left_q - TW'(1);
          if (post_left_q == TW'(1)) begin
            done_o  <= 1'b1;
            state_q <= ST_DONE;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pcap_ctrl.sv
module pcap_ctrl
  import pcap_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int CH_W   = 16,
  parameter int DIV_W  = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DIV_W-1:0]  divider_i,
  input  logic [CNT_W-1:0]  len_units_i,
  input  logic [CNT_W-1:0]  pretrig_i,
  input  logic              trig_i,
  input  logic              ext_clk_i,
  input  logic [CH_W-1:0]   sample_i,
  output logic              strobe_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [CH_W-1:0]   wr_data_o,
  output logic              done_o,
  output logic              trig_seen_o,
  output logic [ADDR_W-1:0] trig_idx_o
);
  logic             trig_en_q, ext_q, fall_q, run, tick, mode_unused;
  logic [DIV_W-1:0] div_q;
  logic [ADDR_W:0]  calc_total, calc_pre, cap_total;

  assign mode_unused = ^mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_en_q <= 1'b0;
      ext_q     <= 1'b0;
      fall_q    <= 1'b0;
      div_q     <= '0;
    end else if (arm_i) begin
      trig_en_q <= mode_i[MODE_TRIG_EN];
      ext_q     <= mode_i[MODE_EXT_CLK];
      fall_q    <= mode_i[MODE_EXT_FALL];
      div_q     <= divider_i;
    end
  end

  pcap_depth_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_calc (
    .units_i  (len_units_i),
    .pre_req_i(pretrig_i),
    .stream_i (mode_i[MODE_STREAM]),
    .total_o  (calc_total),
    .pre_o    (calc_pre)
  );

  pcap_strobe_gen #(.DIV_W(DIV_W)) u_strobe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (arm_i),
    .en_i      (run),
    .ext_sel_i (ext_q),
    .ext_fall_i(fall_q),
    .div_i     (div_q),
    .ext_clk_i (ext_clk_i),
    .tick_o    (tick)
  );

  pcap_sequencer #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm_i),
    .tick_i     (tick),
    .trig_i     (trig_i),
    .trig_en_i  (trig_en_q),
    .sample_i   (sample_i),
    .total_i    (calc_total),
    .pre_i      (calc_pre),
    .run_o      (run),
    .strobe_o   (strobe_o),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .done_o     (done_o),
    .trig_seen_o(trig_seen_o),
    .trig_idx_o (trig_idx_o),
    .total_o    (cap_total)
  );
endmodule

// File: rtl/pcap_ctrl_chk.sv
module pcap_ctrl_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              arm_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              done_i,
  input logic              trig_seen_i,
  input logic [ADDR_W-1:0] trig_idx_i,
  input logic [ADDR_W:0]   total_i
);
  assert_addr_in_region_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> ({1'b0, wr_addr_i} < total_i));

  assert_quiet_after_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !arm_i) |=> (done_i && !wr_en_i));

  assert_done_with_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> (wr_en_i && trig_seen_i));

  assert_trig_on_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_seen_i) |-> (wr_en_i && trig_idx_i == wr_addr_i));

  assert_trig_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_seen_i && !arm_i) |=> (trig_seen_i && $stable(trig_idx_i)));

  assert_arm_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (!done_i && !trig_seen_i && !wr_en_i));
endmodule

bind pcap_ctrl pcap_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .arm_i      (arm_i),
  .wr_en_i    (wr_en_o),
  .wr_addr_i  (wr_addr_o),
  .done_i     (done_o),
  .trig_seen_i(trig_seen_o),
  .trig_idx_i (trig_idx_o),
  .total_i    (cap_total)
);

// File: tb/pcap_ctrl_tb_top.sv
module pcap_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int WD_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        arm_i;
  logic [15:0] mode_i;
  logic [31:0] divider_i, len_units_i, pretrig_i;
  logic        trig_i, ext_clk_i;
  logic [15:0] sample_i;
  logic        strobe_o, wr_en_o, done_o, trig_seen_o;
  logic [AW-1:0] wr_addr_o, trig_idx_o;
  logic [15:0] wr_data_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcap_ctrl #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .arm_i(arm_i), .mode_i(mode_i),
    .divider_i(divider_i), .len_units_i(len_units_i), .pretrig_i(pretrig_i),
    .trig_i(trig_i), .ext_clk_i(ext_clk_i), .sample_i(sample_i),
    .strobe_o(strobe_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .done_o(done_o), .trig_seen_o(trig_seen_o),
    .trig_idx_o(trig_idx_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_total(input int units);
    int u;
    u = (units == 0) ? 1 : units;
    return (u >= DEPTH / 16) ? DEPTH : u * 16;
  endfunction

  function automatic int exp_pre(input int req, input bit stream, input int total);
    int lim, p;
    lim = stream ? ((DEPTH * 10) / 100 / 64) * 64 : ((DEPTH * 90) / 100 / 64) * 64;
    p = (req > lim) ? lim : req;
    p = (p / 64) * 64;
    if (p < 64) p = 64;
    if (p > total - 16) p = total - 16;
    return p;
  endfunction

  // raise_k < 0: trigger condition high from arming; else raised after write raise_k
  task automatic run_capture(input int div, input int units, input int pre_req,
                             input bit stream, input bit ten, input int raise_k);
    int tot, pre, n_eff, j, nwr, exp_idx;
    int c, n, first_c, extra, bad_addr, bad_data, post_wait;
    int ba_act, ba_exp, bd_act, bd_exp;
    bit done_seen, done_wr, fin;
    tot   = exp_total(units);
    pre   = exp_pre(pre_req, stream, tot);
    n_eff = (div == 0) ? 1 : div;
    if (!ten || raise_k < 0) j = pre;
    else j = (raise_k + 1 > pre) ? raise_k + 1 : pre;
    nwr = j + tot - pre;
    exp_idx = j % tot;
    n = 0; first_c = -1; extra = 0; bad_addr = 0; bad_data = 0; post_wait = 0;
    ba_act = 0; ba_exp = 0; bd_act = 0; bd_exp = 0;
    done_seen = 0; done_wr = 0; fin = 0;

    @(negedge clk);
    divider_i   = 32'(div);
    len_units_i = 32'(units);
    pretrig_i   = 32'(pre_req);
    mode_i      = (ten ? 16'h0001 : 16'h0000) | (stream ? 16'h1000 : 16'h0000);
    trig_i      = ten && (raise_k < 0);
    sample_i    = 16'h0;
    arm_i       = 1'b1;
    @(negedge clk);
    arm_i = 1'b0;
    c = 1;
    check(!done_o && !trig_seen_o && !wr_en_o, "R10 arm clears state",
          {done_o, trig_seen_o, wr_en_o}, 0);
    while (!fin) begin
      if (wr_en_o) begin
        if (done_seen) extra++;
        else begin
          if (wr_addr_o != AW'(n % tot)) begin
            if (bad_addr == 0) begin ba_act = wr_addr_o; ba_exp = n % tot; end
            bad_addr++;
          end
          if (wr_data_o != 16'(((n + 1) * n_eff) * 7 + 3)) begin
            if (bad_data == 0) begin bd_act = wr_data_o; bd_exp = 16'(((n + 1) * n_eff) * 7 + 3); end
            bad_data++;
          end
          if (n == 0) first_c = c;
          if (ten && raise_k >= 0 && n == raise_k) trig_i = 1'b1;
          n++;
        end
      end
      if (!done_seen && done_o) begin
        done_seen = 1'b1;
        done_wr   = wr_en_o;
      end
      if (done_seen) begin
        post_wait++;
        if (post_wait > 3 * n_eff + 8) fin = 1'b1;
      end
      if (c > 12000) fin = 1'b1;
      sample_i = 16'(c * 7 + 3);
      if (!fin) begin
        @(negedge clk);
        c++;
      end
    end
    trig_i = 1'b0;

    check(first_c == n_eff + 1, "R1 first write latency", first_c, n_eff + 1);
    check(bad_data == 0, "R1 strobe spacing and sample data", bd_act, bd_exp);
    check(bad_addr == 0, "R2 write address sequence", ba_act, ba_exp);
    check(n == nwr, "R3 R6 write count", n, nwr);
    check(done_seen && done_wr, "R6 done with last write", {done_seen, done_wr}, 3);
    check(extra == 0, "R6 no write after done", extra, 0);
    check(trig_seen_o, "R7 trigger flag", trig_seen_o, 1);
    if (!ten)
      check(trig_idx_o == AW'(exp_idx), "R8 R4 trigger at pre depth", trig_idx_o, exp_idx);
    else
      check(trig_idx_o == AW'(exp_idx), "R5 R7 trigger index", trig_idx_o, exp_idx);
  endtask

  task automatic count_writes(input int cycles, inout int cnt);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (wr_en_o) cnt++;
    end
  endtask

  task automatic ext_run(input bit fall);
    int cnt;
    cnt = 0;
    ext_clk_i = 1'b0;
    repeat (5) @(negedge clk);
    divider_i   = 32'd1;
    len_units_i = 32'd8;
    pretrig_i   = 32'd64;
    mode_i      = fall ? 16'h0006 : 16'h0002;
    trig_i      = 1'b0;
    arm_i       = 1'b1;
    @(negedge clk);
    arm_i = 1'b0;
    count_writes(12, cnt);
    check(cnt == 0, "R9 divider ignored with external clock", cnt, 0);
    ext_clk_i = 1'b1;
    count_writes(12, cnt);
    check(cnt == (fall ? 0 : 1), "R9 rising edge", cnt, fall ? 0 : 1);
    ext_clk_i = 1'b0;
    count_writes(12, cnt);
    check(cnt == 1, "R9 falling edge", cnt, 1);
    for (int p = 0; p < 5; p++) begin
      ext_clk_i = 1'b1;
      count_writes(6, cnt);
      ext_clk_i = 1'b0;
      count_writes(6, cnt);
    end
    check(cnt == 6, "R9 one sample per edge", cnt, 6);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int uset[7];
    int pset[7];
    int dset[5];
    int rset[3];
    uset = '{0, 1, 5, 8, 16, 20, 100};
    pset = '{0, 63, 64, 100, 130, 200, 1000};
    dset = '{0, 1, 2, 3, 5};
    rset = '{-1, 10, 200};
    rst_ni = 1'b0; arm_i = 1'b0; mode_i = '0; divider_i = '0;
    len_units_i = '0; pretrig_i = '0; trig_i = 1'b0; ext_clk_i = 1'b0; sample_i = '0;
    repeat (3) @(negedge clk);
    check({strobe_o, wr_en_o, done_o, trig_seen_o} == 4'b0, "R11 reset flags",
          {strobe_o, wr_en_o, done_o, trig_seen_o}, 0);
    check(wr_addr_o == '0 && trig_idx_o == '0 && wr_data_o == '0, "R11 reset buses",
          wr_addr_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R3/R4/R8: length and pre-depth sweep with trigger disabled
    for (int s = 0; s < 2; s++)
      for (int u = 0; u < 7; u++)
        for (int p = 0; p < 7; p++)
          run_capture(1, uset[u], pset[p], s[0], 1'b0, 0);

    // R1/R5/R7: divider sweep with early, mid and late trigger conditions
    for (int d = 0; d < 5; d++)
      for (int r = 0; r < 3; r++)
        run_capture(dset[d], 8, 100, 1'b0, 1'b1, rset[r]);

    // R4 streaming clamp with a late trigger that wraps the circular region
    run_capture(2, 100, 500, 1'b1, 1'b1, 300);
    run_capture(1, 100, 500, 1'b0, 1'b1, 300);

    // R10: restart in the middle of a run
    @(negedge clk);
    divider_i = 32'd1; len_units_i = 32'd16; pretrig_i = 32'd128;
    mode_i = 16'h0001; trig_i = 1'b0; arm_i = 1'b1;
    @(negedge clk);
    arm_i = 1'b0;
    repeat (40) @(negedge clk);
    check(!done_o, "R10 mid-run not done", done_o, 0);
    run_capture(3, 5, 64, 1'b0, 1'b1, 70);

    ext_run(1'b0);
    ext_run(1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule